// File: doc/BRIEF.md
# Operand and Branch Address Generator

This block is the address-computation stage of a small accumulator-based microcontroller. Each request carries an already-decoded addressing mode together with the instruction's operand byte, an 11-bit page offset, the 2-bit register-bank select, a register number, the program counter of the current instruction and that instruction's length in bytes. For each request the block returns one result. The result holds an internal data address, a flag that routes that address to data RAM or to the special-function-register (SFR) space, a flag that says whether a data address is present at all, and the program counter that control flow moves to.

Requests enter through a valid/ready port. Results leave through a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A result moves on a clock edge where `res_valid` and `res_ready` are both high. `req_ready` stays low while the one-entry result register is full and is not draining, and also during the register-file fetch cycle of a register-indirect request. A held result keeps every field stable until it is taken.

Register-indirect requests read the pointer register through a one-cycle register-file port. The block raises `rf_rd_en` with an index. The register file returns the byte on `rf_rd_data` in the following cycle.

Every program-counter result is derived from the address of the following instruction, which is `req_pc + req_len`. All program-counter arithmetic wraps modulo 65536.

Top module: `opaddr_gen`

## Requirements
- R1: Register mode (`req_mode`=1) returns data address `req_bank*8 + req_reg` with `res_sfr`=0 and `res_dval`=1.
- R2: Direct mode (`req_mode`=2) returns `req_opnd` as the data address with `res_dval`=1. `res_sfr` is 1 exactly when the operand is 128 or more (bit 7 set).
- R3: Indirect mode (`req_mode`=3) raises `rf_rd_en` in the acceptance cycle, with `rf_rd_addr = req_bank*8 + req_reg[0]`, so only R0 or R1 of the bank is read. The result address is the byte returned one cycle later, with `res_dval`=1 and `res_sfr`=0 even for pointer values of 128 and above.
- R4: An indirect result becomes valid two cycles after acceptance. `req_ready` is low in the fetch cycle between them.
- R5: For the plain-advance mode (`req_mode` 0, 6 or 7) and for modes 1 to 3, `res_pc = (req_pc + req_len) mod 65536`. `req_len` holds the length 1, 2 or 3.
- R6: Page-absolute mode (`req_mode`=4) returns bits 15..11 of the following-instruction address, concatenated with the 11-bit `req_page_ofs`.
- R7: Relative mode (`req_mode`=5) returns the following-instruction address plus `req_opnd` read as a signed byte (-128..+127), modulo 65536.
- R8: A non-indirect result becomes valid in the cycle after acceptance.
- R9: While `res_valid` is high and `res_ready` is low, every result field holds its value and `req_ready` is low.
- R10: During reset, `res_valid` and `rf_rd_en` are 0 and `req_ready` is 1.
- R11: Modes 0, 4, 5, 6 and 7 return `res_dval`=0, `res_sfr`=0 and data address 0.
- R12: Every accepted request yields exactly one result, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_mode | input | 3 | Addressing mode: 0 advance, 1 register, 2 direct, 3 indirect, 4 page-absolute, 5 relative, 6/7 advance |
| req_bank | input | 2 | Active register bank |
| req_reg | input | 3 | Register number; bit 0 picks R0/R1 in indirect mode |
| req_opnd | input | 8 | Direct address or signed relative offset |
| req_page_ofs | input | 11 | In-page target field for page-absolute mode |
| req_pc | input | 16 | Address of the current instruction |
| req_len | input | 2 | Instruction length in bytes (1..3) |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rd_addr | output | 5 | Register-file index (bank*8 + register) |
| rf_rd_data | input | 8 | Register-file read data, valid the cycle after the strobe |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_daddr | output | 8 | Internal data address |
| res_sfr | output | 1 | Data address targets the SFR space |
| res_dval | output | 1 | Result carries a data address |
| res_pc | output | 16 | Next or branch-target program counter |

## Verification
Draining a held result and accepting a new request can occur on the same clock edge. The same holds for draining a result and issuing an indirect register-file read, because the drain frees the result register in time to accept the next request. The bench provokes both collisions by holding requests back-to-back while `res_ready` toggles randomly. The scoreboard then judges each result against a bench-computed value in acceptance order. Each result's first valid cycle is compared against the acceptance cycle plus one, or plus two for indirect mode. Together these expose a lost, duplicated or late result at the moment of overlap.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  typedef enum logic [2:0] {
    MODE_SEQ = 3'd0,
    MODE_REG = 3'd1,
    MODE_DIR = 3'd2,
    MODE_IND = 3'd3,
    MODE_ABS = 3'd4,
    MODE_REL = 3'd5
  } mode_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } state_t;

endpackage

// File: rtl/opaddr_dmap.sv
module opaddr_dmap
  import opaddr_pkg::*;
#(
  parameter int DA_W   = 8,
  parameter int OP_W   = 8,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input  mode_t                    mode,
  input  logic [BANK_W-1:0]        bank,
  input  logic [REG_W-1:0]         rsel,
  input  logic [OP_W-1:0]          opnd,
  output logic [DA_W-1:0]          daddr,
  output logic                     is_sfr,
  output logic                     dval,
  output logic                     is_ind,
  output logic [BANK_W+REG_W-1:0]  rf_addr
);

  localparam int RF_AW = BANK_W + REG_W;

  // pointer index: only the lowest register bit survives, so R0/R1 of the bank
  assign rf_addr = {bank, {(REG_W-1){1'b0}}, rsel[0]};
  assign is_ind  = (mode == MODE_IND);

  always_comb begin
    daddr  = '0;
    is_sfr = 1'b0;
    dval   = 1'b0;
    case (mode)
      MODE_REG: begin
        daddr = DA_W'({bank, rsel});
        dval  = 1'b1;
      end
      MODE_DIR: begin
        daddr  = DA_W'(opnd);
        is_sfr = opnd[OP_W-1];
        dval   = 1'b1;
      end
      MODE_IND: begin
        // address comes later from the register file; RAM only
        dval = 1'b1;
      end
      default: begin
        daddr  = '0;
        is_sfr = 1'b0;
        dval   = 1'b0;
      end
    endcase
  end

  initial begin
    if (DA_W < RF_AW) $error("data address narrower than register index");
  end

endmodule

// File: rtl/opaddr_pcgen.sv
module opaddr_pcgen
  import opaddr_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int OP_W   = 8,
  parameter int LEN_W  = 2
) (
  input  mode_t             mode,
  input  logic [PC_W-1:0]   pc,
  input  logic [LEN_W-1:0]  len,
  input  logic [PAGE_W-1:0] page_ofs,
  input  logic [OP_W-1:0]   opnd,
  output logic [PC_W-1:0]   target
);

  localparam int EXT_W = PC_W - OP_W;

  logic [PC_W-1:0] next_pc;
  logic [PC_W-1:0] abs_pc;
  logic [PC_W-1:0] rel_pc;

  // following-instruction address, wraps at the PC width
  assign next_pc = pc + PC_W'(len);

  generate
    if (PAGE_W < PC_W) begin : g_paged
      assign abs_pc = {next_pc[PC_W-1:PAGE_W], page_ofs};
    end else begin : g_flat
      assign abs_pc = page_ofs[PC_W-1:0];
    end
  endgenerate

  assign rel_pc = next_pc + {{EXT_W{opnd[OP_W-1]}}, opnd};

  always_comb begin
    case (mode)
      MODE_ABS: target = abs_pc;
      MODE_REL: target = rel_pc;
      default:  target = next_pc;
    endcase
  end

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int DA_W   = 8,
  parameter int OP_W   = 8,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3,
  parameter int LEN_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2:0]               req_mode,
  input  logic [BANK_W-1:0]        req_bank,
  input  logic [REG_W-1:0]         req_reg,
  input  logic [OP_W-1:0]          req_opnd,
  input  logic [PAGE_W-1:0]        req_page_ofs,
  input  logic [PC_W-1:0]          req_pc,
  input  logic [LEN_W-1:0]         req_len,
  output logic                     rf_rd_en,
  output logic [BANK_W+REG_W-1:0]  rf_rd_addr,
  input  logic [DA_W-1:0]          rf_rd_data,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [DA_W-1:0]          res_daddr,
  output logic                     res_sfr,
  output logic                     res_dval,
  output logic [PC_W-1:0]          res_pc
);

  localparam int RF_AW = BANK_W + REG_W;

  mode_t             mode;
  state_t            state_q;
  logic              accept;
  logic              is_ind;
  logic [DA_W-1:0]   map_daddr;
  logic              map_sfr;
  logic              map_dval;
  logic [RF_AW-1:0]  map_rf_addr;
  logic [PC_W-1:0]   tgt_pc;
  logic [PC_W-1:0]   hold_pc;

  assign mode = mode_t'(req_mode);

  opaddr_dmap #(
    .DA_W(DA_W), .OP_W(OP_W), .BANK_W(BANK_W), .REG_W(REG_W)
  ) u_dmap (
    .mode    (mode),
    .bank    (req_bank),
    .rsel    (req_reg),
    .opnd    (req_opnd),
    .daddr   (map_daddr),
    .is_sfr  (map_sfr),
    .dval    (map_dval),
    .is_ind  (is_ind),
    .rf_addr (map_rf_addr)
  );

  opaddr_pcgen #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .OP_W(OP_W), .LEN_W(LEN_W)
  ) u_pcgen (
    .mode     (mode),
    .pc       (req_pc),
    .len      (req_len),
    .page_ofs (req_page_ofs),
    .opnd     (req_opnd),
    .target   (tgt_pc)
  );

  // take a request only when idle and the result slot is free or draining
  assign req_ready  = (state_q == ST_IDLE) && (!res_valid || res_ready);
  assign accept     = req_valid && req_ready;
  assign rf_rd_en   = accept && is_ind;
  assign rf_rd_addr = map_rf_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_pc <= '0;
    end else if (rf_rd_en) begin
      state_q <= ST_FETCH;
      hold_pc <= tgt_pc;
    end else begin
      state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_daddr <= '0;
      res_sfr   <= 1'b0;
      res_dval  <= 1'b0;
      res_pc    <= '0;
    end else if (accept && !is_ind) begin
      res_valid <= 1'b1;
      res_daddr <= map_daddr;
      res_sfr   <= map_sfr;
      res_dval  <= map_dval;
      res_pc    <= tgt_pc;
    end else if (state_q == ST_FETCH) begin
      res_valid <= 1'b1;
      res_daddr <= rf_rd_data;
      res_sfr   <= 1'b0;
      res_dval  <= 1'b1;
      res_pc    <= hold_pc;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_daddr) && $stable(res_pc)
                                 && $stable(res_sfr) && $stable(res_dval));

  a_r9_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready);

  a_r3_ptr_low_reg: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> rf_rd_addr[REG_W-1:1] == '0);

  a_r4_fetch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |=> !req_ready && !res_valid);

  a_r4_fetch_done: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |=> ##1 res_valid && res_dval && !res_sfr);

  a_r2_sfr_upper: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_sfr |-> res_daddr[DA_W-1] && res_dval);

  a_r11_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_dval |-> res_daddr == '0 && !res_sfr);

endmodule

// File: tb/opaddr_gen_test.sv
module opaddr_gen_test;

  typedef struct packed {
    logic [2:0]  mode;
    logic [7:0]  daddr;
    logic        sfr;
    logic        dval;
    logic [15:0] pc;
    logic [31:0] acc;
  } exp_t;

  localparam int NDIR = 10;
  localparam int NTX  = 600;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [2:0]  req_mode;
  logic [1:0]  req_bank;
  logic [2:0]  req_reg;
  logic [7:0]  req_opnd;
  logic [10:0] req_page_ofs;
  logic [15:0] req_pc;
  logic [1:0]  req_len;
  logic        rf_rd_en;
  logic [4:0]  rf_rd_addr;
  logic [7:0]  rf_rd_data;
  logic        res_valid, res_ready;
  logic [7:0]  res_daddr;
  logic        res_sfr, res_dval;
  logic [15:0] res_pc;

  logic [7:0]  rf_mem [32];
  int          errors = 0;
  int          checks = 0;
  exp_t        q[$];

  always #5 clk = ~clk;

  opaddr_gen uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_bank(req_bank), .req_reg(req_reg),
    .req_opnd(req_opnd), .req_page_ofs(req_page_ofs),
    .req_pc(req_pc), .req_len(req_len),
    .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_daddr(res_daddr), .res_sfr(res_sfr), .res_dval(res_dval), .res_pc(res_pc)
  );

  // register file model: one-cycle read
  always @(posedge clk) begin
    if (rf_rd_en) rf_rd_data <= rf_mem[rf_rd_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R5";
    endcase
  endfunction

  function automatic exp_t model(input logic [2:0] m, input logic [1:0] bank,
                                 input logic [2:0] r, input logic [7:0] op,
                                 input logic [10:0] pofs, input logic [15:0] pc,
                                 input logic [1:0] len);
    exp_t e;
    logic [15:0] nxt;
    nxt = pc + {14'd0, len};
    e = '0;
    e.mode = m;
    e.pc = nxt;
    case (m)
      3'd1: begin e.daddr = {3'b000, bank, r}; e.dval = 1'b1; end
      3'd2: begin e.daddr = op; e.sfr = (op >= 8'd128); e.dval = 1'b1; end
      3'd3: begin e.daddr = rf_mem[{bank, 2'b00, r[0]}]; e.dval = 1'b1; end
      3'd4: e.pc = {nxt[15:11], pofs};
      3'd5: e.pc = nxt + {{8{op[7]}}, op};
      default: ;
    endcase
    return e;
  endfunction

  task automatic set_req(input logic [2:0] m, input logic [1:0] b, input logic [2:0] r,
                         input logic [7:0] op, input logic [10:0] po,
                         input logic [15:0] pc, input logic [1:0] ln);
    req_mode = m; req_bank = b; req_reg = r; req_opnd = op;
    req_page_ofs = po; req_pc = pc; req_len = ln;
  endtask

  task automatic gen_req(input int idx);
    case (idx)
      0: set_req(3'd1, 2'd3, 3'd7, 8'h00, 11'h000, 16'h0100, 2'd1); // R1 bank 3 R7 -> 31
      1: set_req(3'd2, 2'd0, 3'd0, 8'h7F, 11'h000, 16'h0200, 2'd2); // R2 last RAM address
      2: set_req(3'd2, 2'd1, 3'd0, 8'h80, 11'h000, 16'h0300, 2'd2); // R2 first SFR address
      3: set_req(3'd3, 2'd2, 3'd7, 8'h00, 11'h000, 16'h0400, 2'd1); // R3 pointer 0xFF, RAM
      4: set_req(3'd4, 2'd0, 3'd0, 8'h00, 11'h7FF, 16'h07FE, 2'd3); // R6 next crosses page
      5: set_req(3'd5, 2'd0, 3'd0, 8'h80, 11'h000, 16'h0000, 2'd2); // R7 -128 wraps below 0
      6: set_req(3'd5, 2'd0, 3'd0, 8'h7F, 11'h000, 16'hFFF0, 2'd3); // R7 +127 wraps above top
      7: set_req(3'd0, 2'd0, 3'd0, 8'h00, 11'h000, 16'hFFFF, 2'd1); // R5 wrap to 0
      8: set_req(3'd3, 2'd0, 3'd0, 8'h00, 11'h000, 16'h1000, 2'd2); // R3 pointer 0x80
      9: set_req(3'd7, 2'd1, 3'd2, 8'h55, 11'h123, 16'h1234, 2'd2); // R5/R11 spare code
      default: set_req(3'($urandom % 8), 2'($urandom), 3'($urandom), 8'($urandom),
                       11'($urandom), 16'($urandom), 2'(1 + $urandom % 3));
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R12 watchdog expired: actual=%0d expected=%0d", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int    sent;
    int    cyc;
    bit    accepted;
    bit    front_seen;
    bit    fetch_pend;
    exp_t  e;
    exp_t  got;

    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) rf_mem[i] = 8'($urandom);
    rf_mem[17] = 8'hFF;
    rf_mem[0]  = 8'h80;
    rf_rd_data = 8'h00;

    rst_n = 1'b0; req_valid = 1'b0; res_ready = 1'b0;
    set_req(3'd0, 2'd0, 3'd0, 8'h00, 11'h000, 16'h0000, 2'd1);
    sent = 0; cyc = 0; accepted = 0; front_seen = 0; fetch_pend = 0;

    repeat (3) @(negedge clk);
    #1;
    chk(res_valid == 1'b0, "R10", "res_valid in reset", res_valid, 0);
    chk(rf_rd_en == 1'b0, "R10", "rf_rd_en in reset", rf_rd_en, 0);
    chk(req_ready == 1'b1, "R10", "req_ready in reset", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    while ((sent < NTX || q.size() > 0 || req_valid) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      if (accepted) begin req_valid = 1'b0; accepted = 0; end
      res_ready = ($urandom % 4) != 0;
      if (!req_valid && sent < NTX && (sent < NDIR || ($urandom % 4) != 0)) begin
        gen_req(sent);
        req_valid = 1'b1;
      end
      #1;
      if (fetch_pend) begin
        chk(req_ready == 1'b0, "R4", "req_ready in fetch cycle", req_ready, 0);
        fetch_pend = 0;
      end
      if (res_valid && !front_seen) begin
        front_seen = 1;
        if (q.size() == 0) begin
          chk(1'b0, "R12", "result with no request", 1, 0);
        end else begin
          e = q[0];
          if (e.mode == 3'd3)
            chk(cyc == e.acc + 2, "R4", "indirect latency", cyc, e.acc + 2);
          else
            chk(cyc == e.acc + 1, "R8", "direct latency", cyc, e.acc + 1);
        end
      end
      if (res_valid && !res_ready) begin
        chk(req_ready == 1'b0, "R9", "req_ready while held", req_ready, 0);
      end
      if (res_valid && res_ready && q.size() > 0) begin
        e = q.pop_front();
        got = e;
        got.daddr = res_daddr; got.sfr = res_sfr; got.dval = res_dval; got.pc = res_pc;
        if (e.mode == 3'd0 || e.mode > 3'd3)
          chk(got == e, "R11", "no-data fields", {res_dval, res_sfr, res_daddr},
              {e.dval, e.sfr, e.daddr});
        chk(got == e, tag(e.mode), "result {dval,sfr,daddr,pc}",
            {5'd0, res_dval, res_sfr, res_daddr, res_pc}, {5'd0, e.dval, e.sfr, e.daddr, e.pc});
        front_seen = 0;
      end
      if (req_valid && req_ready) begin
        e = model(req_mode, req_bank, req_reg, req_opnd, req_page_ofs, req_pc, req_len);
        e.acc = cyc;
        q.push_back(e);
        if (req_mode == 3'd3) begin
          chk(rf_rd_en == 1'b1, "R3", "read strobe on indirect", rf_rd_en, 1);
          chk(rf_rd_addr == {req_bank, 2'b00, req_reg[0]}, "R3", "pointer index",
              rf_rd_addr, {req_bank, 2'b00, req_reg[0]});
          fetch_pend = 1;
        end else begin
          chk(rf_rd_en == 1'b0, "R3", "no read strobe", rf_rd_en, 0);
        end
        sent++;
        accepted = 1;
      end else begin
        chk(rf_rd_en == 1'b0, "R3", "strobe without acceptance", rf_rd_en, 0);
      end
    end

    chk(q.size() == 0 && sent == NTX, "R12", "outstanding results", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule